// File: doc/BRIEF.md
# TDMA Traffic Slot Bit Sequencer

This block turns one traffic time slot into a serial bit stream, one bit per clock, for the full-rate four-phase differential modulation path. The slot is 324 bits long, and its bit positions are counted from 1 to 324. The caller presents the slot's content on parallel field inputs: the sync word, the slow control word, the colour code, the control-channel locator and up to three payload segments. A single-cycle start strobe captures those fields and selects the link direction. The block then emits the slot with every field at its fixed position.

Guard, ramp and reserved bits come out as zero. The block does not look at the meaning of any field. A bit-position output and an end-of-slot flag let the modulator and the slot timer stay in step with the stream. Two fixed field orderings are built in, one for the mobile-to-base direction and one for the base-to-mobile direction. A parameter can trim the block to a single direction.

Top module: `tslot_seq`

## Requirements
- R1: After reset, `bit_pos` is 0 and `bit_out`, `busy` and `slot_done` are all 0.
- R2: When `start` is high at a clock edge while the block is idle, `bit_pos` is 1 in the following cycle. It then rises by one each cycle up to 324, and returns to 0 in the cycle after 324. `busy` is high exactly while `bit_pos` is not 0.
- R3: With `dir_fwd`=1 captured, the positions are filled as follows. Sync word: 1–28. Slow control word: 29–40. Payload A: 41–170 (130 bits). Colour code: 171–182. Payload B: 183–312 (130 bits). Position 313 is a reserved zero. Locator: 314–324.
- R4: With `dir_fwd`=0 captured, positions 1–6 (guard) and 7–12 (ramp) are zero. The rest are filled as follows. Payload C: 13–28 (16 bits). Sync word: 29–56. Payload A: 57–178, from its low 122 bits. Slow control word: 179–190. Colour code: 191–202. Payload B: 203–324, from its low 122 bits.
- R5: Each field is sent most significant bit first. A 122-bit payload slice starts at bit 121 of its input.
- R6: The field inputs and `dir_fwd` are captured on the accepted start edge. Changes to them later in the slot have no effect on `bit_out`.
- R7: A `start` pulse while a slot is in progress is ignored: `bit_pos` keeps counting and the stream is unchanged.
- R8: `slot_done` is high in exactly the cycle in which `bit_pos` is 324, and in no other cycle.
- R9: `bit_out` is 0 while idle. If `start` is held high, the next slot begins with `bit_pos`=1 two cycles after the cycle with `bit_pos`=324, leaving one idle cycle between slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Slot start strobe, taken only while idle |
| dir_fwd | input | 1 | 1 = base-to-mobile ordering, 0 = mobile-to-base ordering |
| sync_word | input | 28 | Synchronisation/training word |
| slow_ctl | input | 12 | Slow associated control word |
| color_code | input | 12 | Coded verification colour code |
| locator | input | 11 | Coded control-channel locator (forward only) |
| payload_a | input | 130 | First payload segment |
| payload_b | input | 130 | Second payload segment |
| payload_c | input | 16 | Short payload segment (reverse only) |
| bit_out | output | 1 | Serial slot bit |
| bit_pos | output | 9 | Position of `bit_out` in the slot, 0 when idle |
| busy | output | 1 | A slot is being sent |
| slot_done | output | 1 | Last bit of the slot is on `bit_out` |

## Verification
Suppose the position counter skips, stalls or fails to wrap. Then `bit_pos` and `slot_done` go wrong in the very cycle of the fault, and every later bit of that slot lands at a shifted position. Suppose instead the field map or the bit select is wrong. That shows only at the affected positions, as a wrong `bit_out` value. For that reason the bench lights each field alone in both directions and compares all 324 positions of every slot. A snapshot that is not held is caught by changing every input mid-slot: the error appears on `bit_out` in the next cycle that reads the changed field.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

   typedef enum logic [2:0] {
      FLD_ZERO,
      FLD_SYNC,
      FLD_SACCH,
      FLD_CDVCC,
      FLD_CDL,
      FLD_DA,
      FLD_DB,
      FLD_DC
   } fld_e;

   localparam int MAX_FIELDS = 8;

   typedef int   len_arr_t [MAX_FIELDS];
   typedef fld_e fld_arr_t [MAX_FIELDS];

   function automatic int sum_lens(len_arr_t l);
      int s;
      s = 0;
      for (int i = 0; i < MAX_FIELDS; i++) s += l[i];
      return s;
   endfunction

endpackage

// File: rtl/tslot_pos_ctr.sv
module tslot_pos_ctr #(
   parameter int SLOT_BITS = 324,
   parameter int POS_W     = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic [POS_W-1:0] pos,
   output logic             busy,
   output logic             done,
   output logic             take
);
   localparam logic [POS_W-1:0] LAST = POS_W'(SLOT_BITS);

   if (SLOT_BITS < 2 || SLOT_BITS >= (1 << POS_W)) begin : g_chk
      $error("tslot_pos_ctr: SLOT_BITS does not fit POS_W");
   end

   assign busy = (pos != '0);
   assign done = (pos == LAST);
   assign take = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pos <= '0;
      else if (take) pos <= POS_W'(1);
      else if (done) pos <= '0;
      else if (busy) pos <= pos + POS_W'(1);
   end

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && pos == '0) |=> pos == POS_W'(1));                        // R2
   AST_STEP_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (pos != '0 && pos != LAST) |=> pos == $past(pos) + POS_W'(1));     // R7
   AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == LAST) |=> pos == '0);                                      // R2
   AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= LAST);                                                      // R2
endmodule

// File: rtl/tslot_field_map.sv
module tslot_field_map
   import tslot_pkg::*;
#(
   parameter int       SLOT_BITS = 324,
   parameter int       POS_W     = 9,
   parameter int       IDX_W     = 8,
   parameter len_arr_t LENS      = '{28, 12, 130, 12, 130, 1, 11, 0},
   parameter fld_arr_t IDS       = '{FLD_SYNC, FLD_SACCH, FLD_DA, FLD_CDVCC,
                                     FLD_DB, FLD_ZERO, FLD_CDL, FLD_ZERO}
) (
   input  logic [POS_W-1:0] pos,
   output fld_e             fid,
   output logic [IDX_W-1:0] idx
);
   localparam int TOTAL = sum_lens(LENS);

   if (TOTAL != SLOT_BITS) begin : g_chk
      $error("tslot_field_map: field lengths do not add up to SLOT_BITS");
   end

   always_comb begin
      int base;
      int p;
      base = 1;
      p    = int'(pos);
      fid  = FLD_ZERO;
      idx  = '0;
      for (int i = 0; i < MAX_FIELDS; i++) begin
         if (LENS[i] > 0 && p >= base && p < base + LENS[i]) begin
            fid = IDS[i];
            idx = IDX_W'(base + LENS[i] - 1 - p);
         end
         base = base + LENS[i];
      end
   end
endmodule

// File: rtl/tslot_bit_mux.sv
module tslot_bit_mux
   import tslot_pkg::*;
#(
   parameter int SYNC_W   = 28,
   parameter int CTRL_W   = 12,
   parameter int CDL_W    = 11,
   parameter int DATA_W   = 130,
   parameter int DSHORT_W = 16,
   parameter int IDX_W    = 8
) (
   input  fld_e                fid,
   input  logic [IDX_W-1:0]    idx,
   input  logic [SYNC_W-1:0]   sync_q,
   input  logic [CTRL_W-1:0]   sacch_q,
   input  logic [CTRL_W-1:0]   cdvcc_q,
   input  logic [CDL_W-1:0]    cdl_q,
   input  logic [DATA_W-1:0]   da_q,
   input  logic [DATA_W-1:0]   db_q,
   input  logic [DSHORT_W-1:0] dc_q,
   output logic                bit_o
);
   localparam int SYNC_IW = $clog2(SYNC_W);
   localparam int CTRL_IW = $clog2(CTRL_W);
   localparam int CDL_IW  = $clog2(CDL_W);
   localparam int DATA_IW = $clog2(DATA_W);
   localparam int DC_IW   = $clog2(DSHORT_W);

   if (DATA_IW > IDX_W || SYNC_IW > IDX_W || DC_IW > IDX_W) begin : g_chk
      $error("tslot_bit_mux: IDX_W too narrow");
   end

   always_comb begin
      unique case (fid)
         FLD_SYNC:  bit_o = sync_q [idx[SYNC_IW-1:0]];
         FLD_SACCH: bit_o = sacch_q[idx[CTRL_IW-1:0]];
         FLD_CDVCC: bit_o = cdvcc_q[idx[CTRL_IW-1:0]];
         FLD_CDL:   bit_o = cdl_q  [idx[CDL_IW-1:0]];
         FLD_DA:    bit_o = da_q   [idx[DATA_IW-1:0]];
         FLD_DB:    bit_o = db_q   [idx[DATA_IW-1:0]];
         FLD_DC:    bit_o = dc_q   [idx[DC_IW-1:0]];
         default:   bit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/tslot_seq.sv
module tslot_seq
   import tslot_pkg::*;
#(
   parameter int SLOT_BITS   = 324,
   parameter int SYNC_W      = 28,
   parameter int CTRL_W      = 12,
   parameter int CDL_W       = 11,
   parameter int DATA_W      = 130,
   parameter int REV_DATA_W  = 122,
   parameter int DSHORT_W    = 16,
   parameter int GUARD_W     = 6,
   parameter int RAMP_W      = 6,
   parameter int RSVD_W      = 1,
   parameter int DIR_SUPPORT = 0,   // 0 both, 1 forward only, 2 reverse only
   parameter int POS_W       = $clog2(SLOT_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                dir_fwd,
   input  logic [SYNC_W-1:0]   sync_word,
   input  logic [CTRL_W-1:0]   slow_ctl,
   input  logic [CTRL_W-1:0]   color_code,
   input  logic [CDL_W-1:0]    locator,
   input  logic [DATA_W-1:0]   payload_a,
   input  logic [DATA_W-1:0]   payload_b,
   input  logic [DSHORT_W-1:0] payload_c,
   output logic                bit_out,
   output logic [POS_W-1:0]    bit_pos,
   output logic                busy,
   output logic                slot_done
);
   localparam int IDX_W = $clog2(DATA_W);

   localparam len_arr_t FWD_LENS = '{SYNC_W, CTRL_W, DATA_W, CTRL_W,
                                     DATA_W, RSVD_W, CDL_W, 0};
   localparam fld_arr_t FWD_IDS  = '{FLD_SYNC, FLD_SACCH, FLD_DA, FLD_CDVCC,
                                     FLD_DB, FLD_ZERO, FLD_CDL, FLD_ZERO};
   localparam len_arr_t REV_LENS = '{GUARD_W, RAMP_W, DSHORT_W, SYNC_W,
                                     REV_DATA_W, CTRL_W, CTRL_W, REV_DATA_W};
   localparam fld_arr_t REV_IDS  = '{FLD_ZERO, FLD_ZERO, FLD_DC, FLD_SYNC,
                                     FLD_DA, FLD_SACCH, FLD_CDVCC, FLD_DB};

   if (REV_DATA_W > DATA_W) begin : g_chk_rev
      $error("tslot_seq: REV_DATA_W exceeds DATA_W");
   end
   if (DIR_SUPPORT < 0 || DIR_SUPPORT > 2) begin : g_chk_dir
      $error("tslot_seq: DIR_SUPPORT out of range");
   end

   // position counter
   logic take;

   tslot_pos_ctr #(.SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .pos   (bit_pos),
      .busy  (busy),
      .done  (slot_done),
      .take  (take)
   );

   // field snapshot, loaded on an accepted start
   logic [SYNC_W-1:0]   sync_q;
   logic [CTRL_W-1:0]   sacch_q;
   logic [CTRL_W-1:0]   cdvcc_q;
   logic [CDL_W-1:0]    cdl_q;
   logic [DATA_W-1:0]   da_q;
   logic [DATA_W-1:0]   db_q;
   logic [DSHORT_W-1:0] dc_q;
   logic                fwd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= '0;
         sacch_q <= '0;
         cdvcc_q <= '0;
         cdl_q   <= '0;
         da_q    <= '0;
         db_q    <= '0;
         dc_q    <= '0;
         fwd_q   <= 1'b0;
      end else if (take) begin
         sync_q  <= sync_word;
         sacch_q <= slow_ctl;
         cdvcc_q <= color_code;
         cdl_q   <= locator;
         da_q    <= payload_a;
         db_q    <= payload_b;
         dc_q    <= payload_c;
         fwd_q   <= dir_fwd;
      end
   end

   // direction-specific field maps
   fld_e             fid;
   logic [IDX_W-1:0] idx;

   if (DIR_SUPPORT == 0) begin : g_both
      fld_e             fid_f, fid_r;
      logic [IDX_W-1:0] idx_f, idx_r;

      tslot_field_map #(.SLOT_BITS(SLOT_BITS), .POS_W(POS_W), .IDX_W(IDX_W),
                        .LENS(FWD_LENS), .IDS(FWD_IDS)) u_fmap (
         .pos (bit_pos), .fid (fid_f), .idx (idx_f));
      tslot_field_map #(.SLOT_BITS(SLOT_BITS), .POS_W(POS_W), .IDX_W(IDX_W),
                        .LENS(REV_LENS), .IDS(REV_IDS)) u_rmap (
         .pos (bit_pos), .fid (fid_r), .idx (idx_r));

      assign fid = fwd_q ? fid_f : fid_r;
      assign idx = fwd_q ? idx_f : idx_r;
   end else if (DIR_SUPPORT == 1) begin : g_fwd
      tslot_field_map #(.SLOT_BITS(SLOT_BITS), .POS_W(POS_W), .IDX_W(IDX_W),
                        .LENS(FWD_LENS), .IDS(FWD_IDS)) u_fmap (
         .pos (bit_pos), .fid (fid), .idx (idx));
   end else begin : g_rev
      tslot_field_map #(.SLOT_BITS(SLOT_BITS), .POS_W(POS_W), .IDX_W(IDX_W),
                        .LENS(REV_LENS), .IDS(REV_IDS)) u_rmap (
         .pos (bit_pos), .fid (fid), .idx (idx));
   end

   tslot_bit_mux #(.SYNC_W(SYNC_W), .CTRL_W(CTRL_W), .CDL_W(CDL_W),
                   .DATA_W(DATA_W), .DSHORT_W(DSHORT_W), .IDX_W(IDX_W)) u_mux (
      .fid     (fid),
      .idx     (idx),
      .sync_q  (sync_q),
      .sacch_q (sacch_q),
      .cdvcc_q (cdvcc_q),
      .cdl_q   (cdl_q),
      .da_q    (da_q),
      .db_q    (db_q),
      .dc_q    (dc_q),
      .bit_o   (bit_out)
   );

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bit_out);                                               // R9
   AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fid == FLD_ZERO) |-> !bit_out);                                   // R4
   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bit_pos != POS_W'(1)) |-> ($stable(da_q) && $stable(db_q)
                                          && $stable(fwd_q)));           // R6
   AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      slot_done |=> !slot_done);                                         // R8
endmodule

// File: tb/tslot_seq_bench.sv
module tslot_seq_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         dir_fwd = 1'b0;
   logic [27:0]  sync_word = '0;
   logic [11:0]  slow_ctl = '0;
   logic [11:0]  color_code = '0;
   logic [10:0]  locator = '0;
   logic [129:0] payload_a = '0;
   logic [129:0] payload_b = '0;
   logic [15:0]  payload_c = '0;
   logic         bit_out;
   logic [8:0]   bit_pos;
   logic         busy;
   logic         slot_done;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;   // 50 MHz

   tslot_seq u_tslot_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .dir_fwd(dir_fwd),
      .sync_word(sync_word), .slow_ctl(slow_ctl), .color_code(color_code),
      .locator(locator), .payload_a(payload_a), .payload_b(payload_b),
      .payload_c(payload_c), .bit_out(bit_out), .bit_pos(bit_pos),
      .busy(busy), .slot_done(slot_done));

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at t=%0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   function automatic logic [323:0] expect_slot(
      input logic fwd, input logic [27:0] s, input logic [11:0] sa,
      input logic [11:0] cc, input logic [10:0] lo, input logic [129:0] a,
      input logic [129:0] b, input logic [15:0] c);
      if (fwd) return {s, sa, a, cc, b, 1'b0, lo};
      else     return {12'b0, c, s, a[121:0], sa, cc, b[121:0]};
   endfunction

   task automatic load(input logic fwd, input logic [27:0] s, input logic [11:0] sa,
                       input logic [11:0] cc, input logic [10:0] lo,
                       input logic [129:0] a, input logic [129:0] b,
                       input logic [15:0] c);
      dir_fwd = fwd; sync_word = s; slow_ctl = sa; color_code = cc;
      locator = lo; payload_a = a; payload_b = b; payload_c = c;
   endtask

   // Runs a slot from the current inputs; called at a negedge while idle.
   task automatic run_slot(input bit disturb);
      logic [323:0] exp;
      string        rq;
      exp = expect_slot(dir_fwd, sync_word, slow_ctl, color_code, locator,
                        payload_a, payload_b, payload_c);
      rq  = dir_fwd ? "R3/R5" : "R4/R5";
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k <= 324; k++) begin
         check("R2 bit_pos", int'(bit_pos), k);
         check("R2 busy", int'(busy), 1);
         check("R8 slot_done", int'(slot_done), (k == 324) ? 1 : 0);
         check(disturb ? {rq, " R6/R7"} : rq, int'(bit_out), int'(exp[324-k]));
         if (disturb && k == 100) begin
            // R6: change every captured input; R7: start while busy
            load(~dir_fwd, ~sync_word, ~slow_ctl, ~color_code, ~locator,
                 ~payload_a, ~payload_b, ~payload_c);
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      check("R2 wrap", int'(bit_pos), 0);
      check("R9 idle bit", int'(bit_out), 0);
      check("R8 done low", int'(slot_done), 0);
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      logic [129:0] ra, rb;
      repeat (2) @(negedge clk);
      check("R1 bit_pos", int'(bit_pos), 0);
      check("R1 bit_out", int'(bit_out), 0);
      check("R1 busy", int'(busy), 0);
      check("R1 slot_done", int'(slot_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", int'(bit_pos), 0);

      // each field alone, both directions
      for (int d = 0; d < 2; d++) begin
         for (int f = 0; f < 7; f++) begin
            load(d[0], (f == 0) ? '1 : '0, (f == 1) ? '1 : '0, (f == 2) ? '1 : '0,
                 (f == 3) ? '1 : '0, (f == 4) ? '1 : '0, (f == 5) ? '1 : '0,
                 (f == 6) ? '1 : '0);
            run_slot(0);
            @(negedge clk);
         end
         // everything ones: guard/ramp/reserved must stay zero
         load(d[0], '1, '1, '1, '1, '1, '1, '1);
         run_slot(0);
         // alternating pattern checks bit order
         load(d[0], 28'h5A5A5A5, 12'hA53, 12'h3C9, 11'h4D2,
              {65{2'b10}}, {26{5'b10011}}, 16'hB1E4);
         run_slot(0);
      end

      // pseudo-random contents with mid-slot disturbance
      for (int r = 0; r < 6; r++) begin
         ra = {$urandom, $urandom, $urandom, $urandom, $urandom};
         rb = {$urandom, $urandom, $urandom, $urandom, $urandom};
         load(r[0], 28'($urandom), 12'($urandom), 12'($urandom), 11'($urandom),
              ra, rb, 16'($urandom));
         run_slot(1);
         @(negedge clk);
      end

      // R9: start held high -> one idle cycle then next slot
      load(1'b1, 28'hFFF0001, 12'h801, 12'h00F, 11'h401, '1, '0, '1);
      start = 1'b1;
      @(negedge clk);
      check("R9 held start pos1", int'(bit_pos), 1);
      repeat (323) @(negedge clk);
      check("R9 held start last", int'(bit_pos), 324);
      @(negedge clk);
      check("R9 gap idle", int'(bit_pos), 0);
      check("R9 gap bit", int'(bit_out), 0);
      @(negedge clk);
      check("R9 restart", int'(bit_pos), 1);
      check("R9 restart bit", int'(bit_out), 1);
      start = 1'b0;
      repeat (330) @(negedge clk);
      check("R2 idle end", int'(busy), 0);
      finish_run();
   end
endmodule